// File: doc/BRIEF.md
# Software-Coherent Write-Back Data Cache Controller

This block controls a direct-mapped, write-back data cache for one processor in a multiprocessor node that keeps no hardware coherency. The cache is both indexed and tagged with the virtual address. Nothing watches the shared bus. Software keeps copies consistent at its own synchronisation points. It does so by issuing two range commands on a separate command port. The invalidate command drops lines, so that later loads fetch fresh data from memory. The write-back command pushes dirty lines out to main memory and leaves them resident and clean.

The processor side takes single-word loads and stores. Each request carries a flag that marks the page as uncached. A flagged request bypasses the cache and becomes a single-word memory transaction. On the memory side, whole lines move for refills and evictions. A range command is given as a starting line index and a line count. The controller walks the range one line per cycle. It holds the processor off while the walk is in progress, so maintenance never competes with a lookup. It pauses only where a dirty line has to be written out.

Top module: `swc_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` and `cmd_ready` are high, and no response, done pulse or memory request is active. The first cacheable load therefore reads its line from memory.
- R2: A cacheable load that misses reads exactly one line from memory at the line-aligned address (`mem_req_we`=0, `mem_req_word`=0), returns the addressed word, and leaves the line valid and clean. A later load to the same line hits with no memory traffic.
- R3: A cacheable store that hits updates only the cache and creates no memory transaction. A later load returns the stored word.
- R4: A miss whose victim line is valid and dirty first writes the victim line back to the victim's own address. The refill read is issued only after that write.
- R5: A request with `cpu_req_nc`=1 becomes one memory transaction with `mem_req_word`=1 at the request address. The data travels in bits [31:0]. The cache contents are not touched.
- R6: An invalidate command (`cmd_wb`=0) makes each line in the range invalid, so later accesses refetch. Lines outside the range keep hitting.
- R7: Invalidating a dirty line discards its data and issues no memory write.
- R8: A write-back command (`cmd_wb`=1) writes each valid dirty line in the range to memory exactly once, in index order. The lines stay valid and become clean, so a repeated write-back issues no writes. Clean lines are never written.
- R9: A range wraps modulo the line count. A count of zero completes with a done pulse and no effect.
- R10: While a command runs, `cpu_req_ready` is low and no processor response is produced. `cmd_done` is a single-cycle pulse. When a command and a processor request arrive together in idle, the command is taken first.
- R11: On a range that needs no memory traffic, `cmd_done` rises exactly count+1 cycles after the edge that accepts the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a processor request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_nc | input | 1 | Page is uncached; bypass the cache |
| cpu_req_addr | input | AW (32) | Virtual byte address |
| cpu_req_wdata | input | WW (32) | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse for a request |
| cpu_resp_rdata | output | WW (32) | Load data (zero for stores) |
| cmd_valid | input | 1 | Range command present |
| cmd_ready | output | 1 | Controller idle and can take a command |
| cmd_wb | input | 1 | 1 = write-back range, 0 = invalidate range |
| cmd_start | input | log2(LINES) (6) | First line index of the range |
| cmd_count | input | log2(LINES)+1 (7) | Number of lines in the range |
| cmd_done | output | 1 | One-cycle pulse when the range is finished |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_word | output | 1 | 1 = single-word uncached access, 0 = whole line |
| mem_req_addr | output | AW (32) | Byte address (line-aligned for line accesses) |
| mem_req_wline | output | LINE_BYTES*8 (128) | Write data (word in [31:0] for uncached access) |
| mem_resp_valid | input | 1 | Read data returned |
| mem_resp_rline | input | LINE_BYTES*8 (128) | Read data (word in [31:0] for uncached access) |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-byte lines and 64 lines. The index is therefore bits [9:4] and the tag starts at bit 10. Addresses 0x000 and 0x400 collide on line 0, which brings dirty eviction and invalidate-over-dirty within reach in a few accesses. A range that starts at line 63 with a count of 3 exercises wrap-around across both ends of the array. The memory model always accepts and answers reads one cycle later. Clean walks therefore have exact, predictable durations, and the order of memory events can be compared entry by entry.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMP, ST_VWB, ST_FREQ, ST_FWAIT, ST_RERD,
    ST_NCREQ, ST_NCWAIT, ST_WALK, ST_CWB
  } swc_state_e;
endpackage

// File: rtl/swc_tag_store.sv
`timescale 1ns/1ps
module swc_tag_store #(
  parameter int LINES = 64,
  parameter int TAGW  = 22,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] ridx,
  output logic            rd_valid,
  output logic            rd_dirty,
  output logic [TAGW-1:0] rd_tag,
  input  logic [IDXW-1:0] widx,
  input  logic [TAGW-1:0] wtag,
  input  logic            fill_en,
  input  logic            dirty_en,
  input  logic            inv_en,
  input  logic            clean_en
);
  logic [LINES-1:0] vld;
  logic [LINES-1:0] drt;
  logic [TAGW-1:0]  tags [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      drt <= '0;
    end else begin
      if (fill_en) begin
        vld[widx] <= 1'b1;
        drt[widx] <= 1'b0;
      end
      if (dirty_en) drt[widx] <= 1'b1;
      if (inv_en) begin
        vld[widx] <= 1'b0;
        drt[widx] <= 1'b0;
      end
      if (clean_en) drt[widx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tags[widx] <= wtag;
  end

  assign rd_valid = vld[ridx];
  assign rd_dirty = drt[ridx];
  assign rd_tag   = tags[ridx];

  // R8
  clean_valid_chk: assert property (@(posedge clk) disable iff (rst)
    clean_en |-> (vld[widx] && drt[widx]));

  // R6
  inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !vld[$past(widx)]);

  // R2
  one_update_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fill_en, dirty_en, inv_en, clean_en}));
endmodule

// File: rtl/swc_data_store.sv
`timescale 1ns/1ps
module swc_data_store #(
  parameter int LINES = 64,
  parameter int WW    = 32,
  parameter int WPL   = 4,
  localparam int IDXW = $clog2(LINES),
  localparam int LW   = WW * WPL
) (
  input  logic            clk,
  input  logic [IDXW-1:0] raddr,
  output logic [LW-1:0]   rdata,
  input  logic [IDXW-1:0] waddr,
  input  logic [WPL-1:0]  we,
  input  logic [LW-1:0]   wdata
);
  for (genvar g = 0; g < WPL; g++) begin : g_bank
    logic [WW-1:0] mem [LINES];
    logic [WW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*WW +: WW];
      rd_q <= mem[raddr];
    end
    assign rdata[g*WW +: WW] = rd_q;
  end
endmodule

// File: rtl/swc_cache_ctrl.sv
`timescale 1ns/1ps
module swc_cache_ctrl
  import swc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 64,
  localparam int LW   = LINE_BYTES * 8,
  localparam int WPL  = LW / WW,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int BSW  = $clog2(WW / 8),
  localparam int WSW  = (WPL > 1) ? $clog2(WPL) : 1,
  localparam int IDXW = $clog2(LINES),
  localparam int TAGW = AW - IDXW - OFFW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_req_valid,
  output logic            cpu_req_ready,
  input  logic            cpu_req_we,
  input  logic            cpu_req_nc,
  input  logic [AW-1:0]   cpu_req_addr,
  input  logic [WW-1:0]   cpu_req_wdata,
  output logic            cpu_resp_valid,
  output logic [WW-1:0]   cpu_resp_rdata,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_wb,
  input  logic [IDXW-1:0] cmd_start,
  input  logic [IDXW:0]   cmd_count,
  output logic            cmd_done,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic            mem_req_word,
  output logic [AW-1:0]   mem_req_addr,
  output logic [LW-1:0]   mem_req_wline,
  input  logic            mem_resp_valid,
  input  logic [LW-1:0]   mem_resp_rline
);
  swc_state_e      state;
  logic [AW-1:0]   r_addr;
  logic            r_we;
  logic [WW-1:0]   r_wdata;
  logic            r_wb;
  logic [IDXW-1:0] idx_q;
  logic [IDXW:0]   remain;

  logic [TAGW-1:0] r_tag;
  logic [WSW-1:0]  ws;
  logic [IDXW-1:0] raddr;
  logic [LW-1:0]   line_q;
  logic [WW-1:0]   rword;
  logic            tv_valid, tv_dirty;
  logic [TAGW-1:0] tv_tag;
  logic            hit;
  logic            fill_en, dirty_en, inv_en, clean_en;
  logic [WPL-1:0]  d_we;
  logic [LW-1:0]   d_wdata;

  assign r_tag = r_addr[AW-1 -: TAGW];
  assign ws    = r_addr[OFFW-1:BSW];
  assign raddr = (state == ST_IDLE) ? cpu_req_addr[OFFW +: IDXW] : idx_q;
  assign hit   = tv_valid && (tv_tag == r_tag);

  assign cmd_ready     = (state == ST_IDLE);
  assign cpu_req_ready = (state == ST_IDLE) && !cmd_valid;

  swc_tag_store #(.LINES(LINES), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst(rst), .ridx(idx_q),
    .rd_valid(tv_valid), .rd_dirty(tv_dirty), .rd_tag(tv_tag),
    .widx(idx_q), .wtag(r_tag),
    .fill_en(fill_en), .dirty_en(dirty_en), .inv_en(inv_en), .clean_en(clean_en)
  );

  swc_data_store #(.LINES(LINES), .WW(WW), .WPL(WPL)) u_data (
    .clk(clk), .raddr(raddr), .rdata(line_q),
    .waddr(idx_q), .we(d_we), .wdata(d_wdata)
  );

  always_comb begin
    rword = '0;
    for (int i = 0; i < WPL; i++)
      if (ws == i[WSW-1:0]) rword = line_q[i*WW +: WW];
  end

  always_comb begin
    fill_en = 1'b0; dirty_en = 1'b0; inv_en = 1'b0; clean_en = 1'b0;
    d_we = '0; d_wdata = {WPL{r_wdata}};
    mem_req_valid = 1'b0; mem_req_we = 1'b0; mem_req_word = 1'b0;
    mem_req_addr = {r_tag, idx_q, {OFFW{1'b0}}};
    mem_req_wline = line_q;
    case (state)
      ST_CMP: if (hit && r_we) begin
        d_we[ws] = 1'b1;
        dirty_en = 1'b1;
      end
      ST_VWB, ST_CWB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = {tv_tag, idx_q, {OFFW{1'b0}}};
        clean_en      = mem_req_ready;
      end
      ST_FREQ: mem_req_valid = 1'b1;
      ST_FWAIT: if (mem_resp_valid) begin
        d_we    = '1;
        d_wdata = mem_resp_rline;
        fill_en = 1'b1;
      end
      ST_NCREQ: begin
        mem_req_valid = 1'b1;
        mem_req_word  = 1'b1;
        mem_req_we    = r_we;
        mem_req_addr  = r_addr;
        mem_req_wline = {{(LW-WW){1'b0}}, r_wdata};
      end
      ST_WALK: if (remain != '0 && !r_wb) inv_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      r_addr <= '0; r_we <= 1'b0; r_wdata <= '0; r_wb <= 1'b0;
      idx_q <= '0; remain <= '0;
      cpu_resp_valid <= 1'b0; cpu_resp_rdata <= '0; cmd_done <= 1'b0;
    end else begin
      cpu_resp_valid <= 1'b0;
      cmd_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            r_wb   <= cmd_wb;
            idx_q  <= cmd_start;
            remain <= cmd_count;
            state  <= ST_WALK;
          end else if (cpu_req_valid) begin
            r_addr  <= cpu_req_addr;
            r_we    <= cpu_req_we;
            r_wdata <= cpu_req_wdata;
            idx_q   <= cpu_req_addr[OFFW +: IDXW];
            state   <= cpu_req_nc ? ST_NCREQ : ST_CMP;
          end
        end
        ST_CMP: begin
          if (hit) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_rdata <= r_we ? '0 : rword;
            state <= ST_IDLE;
          end else if (tv_valid && tv_dirty) state <= ST_VWB;
          else state <= ST_FREQ;
        end
        ST_VWB:   if (mem_req_ready) state <= ST_FREQ;
        ST_FREQ:  if (mem_req_ready) state <= ST_FWAIT;
        ST_FWAIT: if (mem_resp_valid) state <= ST_RERD;
        ST_RERD:  state <= ST_CMP;
        ST_NCREQ: if (mem_req_ready) begin
          if (r_we) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_rdata <= '0;
            state <= ST_IDLE;
          end else state <= ST_NCWAIT;
        end
        ST_NCWAIT: if (mem_resp_valid) begin
          cpu_resp_valid <= 1'b1;
          cpu_resp_rdata <= mem_resp_rline[WW-1:0];
          state <= ST_IDLE;
        end
        ST_WALK: begin
          if (remain == '0) begin
            cmd_done <= 1'b1;
            state <= ST_IDLE;
          end else if (r_wb && tv_valid && tv_dirty) begin
            state <= ST_CWB;
          end else begin
            idx_q  <= idx_q + 1'b1;
            remain <= remain - 1'b1;
          end
        end
        ST_CWB: if (mem_req_ready) begin
          idx_q  <= idx_q + 1'b1;
          remain <= remain - 1'b1;
          state  <= ST_WALK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FWAIT && mem_resp_valid) |=> (tv_valid && !tv_dirty));

  // R4
  victim_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_we && !mem_req_word) |-> !(tv_valid && tv_dirty));

  // R7
  inv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WALK && !r_wb) |-> !mem_req_valid);

  // R10
  walk_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WALK || state == ST_CWB) |-> !cpu_resp_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);
endmodule

// File: tb/sim_swc_cache_ctrl.sv
`timescale 1ns/1ps
module sim_swc_cache_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         cpu_req_valid = 0, cpu_req_we = 0, cpu_req_nc = 0;
  logic [31:0]  cpu_req_addr = 0, cpu_req_wdata = 0;
  logic         cpu_req_ready, cpu_resp_valid;
  logic [31:0]  cpu_resp_rdata;
  logic         cmd_valid = 0, cmd_wb = 0;
  logic [5:0]   cmd_start = 0;
  logic [6:0]   cmd_count = 0;
  logic         cmd_ready, cmd_done;
  logic         mem_req_valid, mem_req_we, mem_req_word;
  logic         mem_req_ready = 1'b1;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wline;
  logic         mem_resp_valid;
  logic [127:0] mem_resp_rline;

  swc_cache_ctrl u0 (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_nc(cpu_req_nc),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_wb(cmd_wb),
    .cmd_start(cmd_start), .cmd_count(cmd_count), .cmd_done(cmd_done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_word(mem_req_word),
    .mem_req_addr(mem_req_addr), .mem_req_wline(mem_req_wline),
    .mem_resp_valid(mem_resp_valid), .mem_resp_rline(mem_resp_rline)
  );

  int checks = 0;
  int errors = 0;

  // memory model: word at byte address a starts as A0000000 + a/4
  logic [31:0] bmem [1024];
  logic [33:0] evq [$];
  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 1024; i++) bmem[i] = 32'hA000_0000 + i;
    end else if (mem_req_valid) begin
      evq.push_back({mem_req_we, mem_req_word, mem_req_addr});
      if (mem_req_we) begin
        if (mem_req_word) bmem[int'(mem_req_addr[11:2])] = mem_req_wline[31:0];
        else for (int w = 0; w < 4; w++)
          bmem[int'(mem_req_addr[11:4])*4 + w] = mem_req_wline[w*32 +: 32];
      end else begin
        mem_resp_valid <= 1'b1;
        if (mem_req_word) mem_resp_rline <= {96'b0, bmem[int'(mem_req_addr[11:2])]};
        else for (int w = 0; w < 4; w++)
          mem_resp_rline[w*32 +: 32] <= bmem[int'(mem_req_addr[11:4])*4 + w];
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q [$];
  bit          cmp_q [$];
  string       rq_q  [$];
  always @(negedge clk) begin
    if (!rst && cpu_resp_valid) begin
      if (exp_q.size() == 0) chk(0, "unexpected response", cpu_resp_rdata, 0);
      else begin
        logic [31:0] e;
        bit c;
        string r;
        e = exp_q.pop_front(); c = cmp_q.pop_front(); r = rq_q.pop_front();
        if (c) chk(cpu_resp_rdata == e, r, cpu_resp_rdata, e);
      end
    end
  end

  task automatic wait_accept();
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic cpu_op(input logic we, input logic nc, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [31:0] exp, input string rq);
    exp_q.push_back(exp); cmp_q.push_back(!we); rq_q.push_back(rq);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_nc = nc;
    cpu_req_addr = addr; cpu_req_wdata = wd;
    wait_accept();
  endtask

  task automatic run_cmd(input logic wb, input logic [5:0] st, input logic [6:0] cnt, output int k);
    @(negedge clk);
    cmd_valid = 1; cmd_wb = wb; cmd_start = st; cmd_count = cnt;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk(cpu_req_ready == 0, "R10 ready low during walk", 32'(cpu_req_ready), 0);
    k = 0;
    while (!cmd_done) begin @(negedge clk); k++; end
  endtask

  task automatic ev_n(input int base, input int n, input string rq);
    chk(evq.size() - base == n, rq, evq.size() - base, n);
  endtask

  task automatic ev_at(input int pos, input logic we, input logic word,
                       input logic [31:0] addr, input string rq);
    logic [33:0] e;
    e = (pos < evq.size()) ? evq[pos] : 34'h3_FFFF_FFFF;
    chk(e == {we, word, addr}, rq, e[31:0], addr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b, k;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1, "R1 cpu_req_ready", 32'(cpu_req_ready), 1);
    chk(cmd_ready == 1, "R1 cmd_ready", 32'(cmd_ready), 1);
    chk(!cpu_resp_valid && !cmd_done && !mem_req_valid, "R1 outputs idle",
        {29'b0, cpu_resp_valid, cmd_done, mem_req_valid}, 0);

    // R1/R2: first load misses and fills
    b = evq.size();
    cpu_op(0, 0, 32'h004, 0, 32'hA000_0001, "R2 miss load data");
    ev_n(b, 1, "R1 R2 one line read");
    ev_at(b, 0, 0, 32'h000, "R2 line-aligned read");
    b = evq.size();
    cpu_op(0, 0, 32'h008, 0, 32'hA000_0002, "R2 hit load data");
    ev_n(b, 0, "R2 hit no traffic");

    // R3 store hit
    b = evq.size();
    cpu_op(1, 0, 32'h004, 32'h1111_1111, 0, "R3 store");
    cpu_op(0, 0, 32'h004, 0, 32'h1111_1111, "R3 load after store");
    ev_n(b, 0, "R3 no memory write");

    // R4 dirty eviction
    b = evq.size();
    cpu_op(0, 0, 32'h404, 0, 32'hA000_0101, "R4 conflict load");
    ev_n(b, 2, "R4 two events");
    ev_at(b, 1, 0, 32'h000, "R4 victim written first");
    ev_at(b + 1, 0, 0, 32'h400, "R4 refill second");
    chk(bmem[1] == 32'h1111_1111, "R4 victim data", bmem[1], 32'h1111_1111);

    // R5 uncached bypass
    b = evq.size();
    cpu_op(1, 1, 32'h404, 32'h2222_2222, 0, "R5 nc store");
    ev_n(b, 1, "R5 nc store one event");
    ev_at(b, 1, 1, 32'h404, "R5 nc word write");
    chk(bmem[12'h101] == 32'h2222_2222, "R5 nc memory", bmem[12'h101], 32'h2222_2222);
    b = evq.size();
    cpu_op(0, 0, 32'h404, 0, 32'hA000_0101, "R5 cache untouched");
    ev_n(b, 0, "R5 cached hit no traffic");
    cpu_op(0, 1, 32'h404, 0, 32'h2222_2222, "R5 nc load");
    ev_at(b, 0, 1, 32'h404, "R5 nc word read");

    // R6/R7 invalidate over dirty line
    cpu_op(1, 0, 32'h408, 32'h3333_3333, 0, "R7 dirty store");
    cpu_op(0, 0, 32'h010, 0, 32'hA000_0004, "R6 fill line 1");
    b = evq.size();
    run_cmd(0, 6'd0, 7'd1, k);
    ev_n(b, 0, "R7 invalidate writes nothing");
    chk(k == 2, "R11 invalidate duration", k, 2);
    cpu_op(0, 0, 32'h010, 0, 32'hA000_0004, "R6 outside range hits");
    ev_n(b, 0, "R6 outside range no traffic");
    cpu_op(0, 0, 32'h408, 0, 32'hA000_0102, "R7 discarded data refetched");
    ev_n(b, 1, "R6 refetch one event");
    ev_at(b, 0, 0, 32'h400, "R6 refetch read");

    // R8/R9 write-back with wrap
    cpu_op(1, 0, 32'h010, 32'h4444_4444, 0, "R8 dirty line 1");
    cpu_op(1, 0, 32'h400, 32'h5555_5555, 0, "R8 dirty line 0");
    cpu_op(0, 0, 32'h3F0, 0, 32'hA000_00FC, "R8 clean line 63");
    b = evq.size();
    run_cmd(1, 6'd63, 7'd3, k);
    ev_n(b, 2, "R8 R9 two writes");
    ev_at(b, 1, 0, 32'h400, "R9 wrapped line 0 written");
    ev_at(b + 1, 1, 0, 32'h010, "R8 line 1 written");
    chk(bmem[12'h100] == 32'h5555_5555, "R8 memory line 0", bmem[12'h100], 32'h5555_5555);
    chk(bmem[4] == 32'h4444_4444, "R8 memory line 1", bmem[4], 32'h4444_4444);
    b = evq.size();
    run_cmd(1, 6'd63, 7'd3, k);
    ev_n(b, 0, "R8 second write-back no writes");
    chk(k == 4, "R11 clean write-back duration", k, 4);
    cpu_op(0, 0, 32'h010, 0, 32'h4444_4444, "R8 line stays valid");
    ev_n(b, 0, "R8 still hits");

    // R9 zero count
    run_cmd(0, 6'd1, 7'd0, k);
    chk(k == 1, "R9 R11 zero count duration", k, 1);
    cpu_op(0, 0, 32'h010, 0, 32'h4444_4444, "R9 zero count no effect");
    ev_n(b, 0, "R9 zero count no traffic");

    // R10 command priority over simultaneous request
    exp_q.push_back(32'h4444_4444); cmp_q.push_back(1); rq_q.push_back("R10 load after command");
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = 0; cpu_req_nc = 0; cpu_req_addr = 32'h010;
    cmd_valid = 1; cmd_wb = 0; cmd_start = 6'd1; cmd_count = 7'd1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk(cpu_req_ready == 0, "R10 command taken first", 32'(cpu_req_ready), 0);
    wait_accept();
    ev_n(b, 1, "R10 load refetched after invalidate");
    ev_at(b, 0, 0, 32'h010, "R10 refetch address");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule